// File: doc/BRIEF.md
# Reversible Full-Cycle Address Stepper

This block generates memory addresses for a self-test engine. A shift register with linear feedback visits every address of a W-bit space in a fixed pseudo-random order, and that order includes the all-zero address. A zero-detect term on the register bits that stay inside the register bends the feedback, so the register passes through the all-zero state instead of getting stuck there. A direction input makes the register shift the other way, using the mirrored taps and the same zero-detect. The descending order is then the exact reverse of the ascending one, which is what a March algorithm needs from its address stepper.

A synchronous reset loads a seed address, set by a parameter. Each enabled clock moves one step in the chosen direction, and the address holds while enable is low. A terminal flag marks the last address of a pass in the current direction. The step after that returns the stepper to the seed. The width can be set from 3 to 16 bits, and a primitive polynomial is chosen inside the block for each width.

Top module: `alfsr_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next `addr` is the parameter `SEED`. Reset takes priority over `en`.
- R2: An enabled up step (`en`=1, `dir_down`=0) shifts `addr` one place toward the MSB. The new LSB is the XOR of the tapped bits, XORed with 1 when bits W-2..0 are all zero. For W=4 the taps are bits 3 and 0, so from 0001 the up sequence is 0011, 0111, 1111, 1110, 1101, 1010, 0101, 1011, 0110, 1100, 1001, 0010, 0100, 1000, 0000, 0001.
- R3: Starting from the seed, 2^W enabled up steps visit every W-bit address exactly once and end back on the seed.
- R4: The up step from 1 followed by W-1 zeros goes to all-zero, and the up step from all-zero goes to 0…01.
- R5: An enabled down step (`dir_down`=1) is the exact inverse of an up step. A down pass from the seed visits the addresses of the up pass in reverse order.
- R6: While `en` is low, `addr` holds its value, whatever `dir_down` is.
- R7: With `dir_down`=0, `last` is 1 exactly when `addr` is the up-predecessor of the seed. For W=4 and SEED=1 that address is 0000.
- R8: With `dir_down`=1, `last` is 1 exactly when `addr` is the up-successor of the seed. For W=4 and SEED=1 that address is 0011.
- R9: A change of `dir_down` applies to the very next enabled step, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset; loads the seed |
| en | input | 1 | Step enable |
| dir_down | input | 1 | 0 selects the ascending order, 1 the descending order |
| addr | output | W | Current address |
| last | output | 1 | Final address of a pass in the selected direction |

## Verification
A short vector table at W=4 mixes up steps, down steps, holds with either direction and direction flips. It compares every address and flag against the hand-derived order, so a wrong tap, a missing zero-detect or a delayed direction change each shows up at a specific step. A full up pass at W=12 records the whole sequence and checks that no address repeats, that zero is entered and left at the right places, and that the flag fires once. A following down pass is compared entry by entry with that record read backwards, which is how the mirror property is told apart from a down step that merely moves through some other cycle. Directed tests cover the reset value, reset priority over enable, and the flag in both directions at reset.

// File: rtl/alfsr_pkg.sv
package alfsr_pkg;

  localparam int unsigned MAX_W = 16;
  typedef logic [MAX_W-1:0] word_t;

  // Exponents below W of a primitive polynomial x^W + ... + 1 (bit e = x^e).
  function automatic word_t poly_terms(int unsigned w);
    case (w)
      3:       return 16'h0005;
      4:       return 16'h0009;
      5:       return 16'h0009;
      6:       return 16'h0021;
      7:       return 16'h0041;
      8:       return 16'h0071;
      9:       return 16'h0021;
      10:      return 16'h0081;
      11:      return 16'h0201;
      12:      return 16'h0053;
      13:      return 16'h001B;
      14:      return 16'h002B;
      15:      return 16'h4001;
      default: return 16'hA011;
    endcase
  endfunction

  // Register bit positions that feed the XOR: term x^e maps to bit w-1-e.
  function automatic word_t tap_bits(int unsigned w);
    word_t e;
    word_t t;
    e = poly_terms(w);
    t = '0;
    for (int unsigned i = 0; i < MAX_W; i++)
      if (i < w && e[i]) t[w-1-i] = 1'b1;
    return t;
  endfunction

  // Mask covering bits w-2..0 (the bits that stay inside on an up shift).
  function automatic word_t low_mask(int unsigned w);
    word_t m;
    m = '0;
    for (int unsigned i = 0; i < MAX_W; i++)
      if (i + 1 < w) m[i] = 1'b1;
    return m;
  endfunction

  function automatic word_t full_mask(int unsigned w);
    word_t m;
    m = '0;
    for (int unsigned i = 0; i < MAX_W; i++)
      if (i < w) m[i] = 1'b1;
    return m;
  endfunction

  // Ascending step: shift toward MSB, new LSB from taps plus zero-detect.
  function automatic word_t step_up(word_t v, int unsigned w);
    word_t kept;
    logic  zero_rest;
    logic  fb;
    kept      = v & low_mask(w);
    zero_rest = (kept == '0);
    fb        = (^(v & tap_bits(w))) ^ zero_rest;
    return ((kept << 1) | word_t'(fb)) & full_mask(w);
  endfunction

  // Descending step: shift toward LSB, rebuild the dropped MSB.
  function automatic word_t step_down(word_t p, int unsigned w);
    word_t upper;
    logic  zero_rest;
    logic  top;
    upper     = (p >> 1) & low_mask(w);
    zero_rest = (upper == '0);
    top       = p[0] ^ (^(upper & tap_bits(w) & low_mask(w))) ^ zero_rest;
    return (upper | (word_t'(top) << (w - 1))) & full_mask(w);
  endfunction

endpackage

// File: rtl/alfsr_next_state.sv
module alfsr_next_state
  import alfsr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur,
  input  logic         dir_down,
  output logic [W-1:0] nxt_fwd,
  output logic [W-1:0] nxt_bwd,
  output logic [W-1:0] nxt
);
  word_t cur_w;

  always_comb begin
    cur_w   = '0;
    cur_w[W-1:0] = cur;
  end

  word_t fwd_w;
  word_t bwd_w;

  always_comb begin
    fwd_w = step_up(cur_w, W);
    bwd_w = step_down(cur_w, W);
  end

  assign nxt_fwd = fwd_w[W-1:0];
  assign nxt_bwd = bwd_w[W-1:0];
  assign nxt     = dir_down ? nxt_bwd : nxt_fwd;
endmodule

// File: rtl/alfsr_state_reg.sv
module alfsr_state_reg #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= SEED;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/alfsr_terminal.sv
module alfsr_terminal
  import alfsr_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic [W-1:0] cur,
  input  logic         dir_down,
  output logic         end_up,
  output logic         end_dn,
  output logic         last
);
  localparam word_t SEED_W  = word_t'(SEED);
  localparam word_t PRED_W  = step_down(SEED_W, W);
  localparam word_t SUCC_W  = step_up(SEED_W, W);
  localparam logic [W-1:0] SEED_PRED = PRED_W[W-1:0];
  localparam logic [W-1:0] SEED_SUCC = SUCC_W[W-1:0];

  assign end_up = (cur == SEED_PRED);
  assign end_dn = (cur == SEED_SUCC);
  assign last   = dir_down ? end_dn : end_up;
endmodule

// File: rtl/alfsr_addr_gen.sv
module alfsr_addr_gen #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         dir_down,
  output logic [W-1:0] addr,
  output logic         last
);
  logic [W-1:0] cur;
  logic [W-1:0] nxt;
  logic [W-1:0] nxt_fwd;
  logic [W-1:0] nxt_bwd;
  logic         end_up;
  logic         end_dn;

  alfsr_next_state #(.W(W)) u_next (
    .cur      (cur),
    .dir_down (dir_down),
    .nxt_fwd  (nxt_fwd),
    .nxt_bwd  (nxt_bwd),
    .nxt      (nxt)
  );

  alfsr_state_reg #(.W(W), .SEED(SEED)) u_reg (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .nxt (nxt),
    .q   (cur)
  );

  alfsr_terminal #(.W(W), .SEED(SEED)) u_term (
    .cur      (cur),
    .dir_down (dir_down),
    .end_up   (end_up),
    .end_dn   (end_dn),
    .last     (last)
  );

  assign addr = cur;
endmodule

// File: rtl/alfsr_addr_gen_chk.sv
module alfsr_addr_gen_chk #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] SEED = 1
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         dir_down,
  input logic [W-1:0] addr,
  input logic         last
);
  localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};

  // R6: no step without enable
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(addr));

  // R2: an enabled up step always changes the address
  a_r2_moves: assert property (@(posedge clk) disable iff (rst)
    (en && !dir_down) |=> addr != $past(addr));

  // R4: all-zero is entered from the top-bit-only address
  a_r4_zero_entry: assert property (@(posedge clk) disable iff (rst)
    (en && !dir_down && addr == TOP_ONLY) |=> addr == '0);

  // R5: a down step undoes the preceding up step
  a_r5_inverse: assert property (@(posedge clk) disable iff (rst)
    (en && !dir_down) ##1 (en && dir_down) |=> addr == $past(addr, 2));

  // R7: after the up-terminal address the next up step lands on the seed
  a_r7_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (en && !dir_down && last) |=> addr == SEED);

  // R8: after the down-terminal address the next down step lands on the seed
  a_r8_wrap_dn: assert property (@(posedge clk) disable iff (rst)
    (en && dir_down && last) |=> addr == SEED);
endmodule

bind alfsr_addr_gen alfsr_addr_gen_chk #(.W(W), .SEED(SEED)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .dir_down (dir_down),
  .addr     (addr),
  .last     (last)
);

// File: tb/sim_alfsr_addr_gen.sv
`timescale 1ns/1ps
module sim_alfsr_addr_gen;
  localparam int unsigned WA = 4;
  localparam int unsigned WB = 12;
  localparam int unsigned NB = 1 << WB;
  localparam int unsigned NV = 29;

  // entry = {en, dir_down, expected addr[3:0], expected last}
  localparam logic [6:0] VEC [NV] = '{
    7'b10_0011_0, 7'b10_0111_0, 7'b00_0111_0, 7'b10_1111_0,
    7'b11_0111_0, 7'b11_0011_1, 7'b11_0001_0, 7'b11_0000_0,
    7'b11_1000_0, 7'b01_1000_0, 7'b10_0000_1, 7'b10_0001_0,
    7'b01_0001_0,
    7'b10_0011_0, 7'b10_0111_0, 7'b10_1111_0, 7'b10_1110_0,
    7'b10_1101_0, 7'b10_1010_0, 7'b10_0101_0, 7'b10_1011_0,
    7'b10_0110_0, 7'b10_1100_0, 7'b10_1001_0, 7'b10_0010_0,
    7'b10_0100_0, 7'b10_1000_0, 7'b10_0000_1, 7'b10_0001_0
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1, en = 1'b0, dn = 1'b0;
  logic [WA-1:0] addr;
  logic          last;
  logic          rst_b = 1'b1, en_b = 1'b0, dn_b = 1'b0;
  logic [WB-1:0] addr_b;
  logic          last_b;

  alfsr_addr_gen #(.W(WA), .SEED(4'd1)) u0 (
    .clk(clk), .rst(rst), .en(en), .dir_down(dn), .addr(addr), .last(last));
  alfsr_addr_gen #(.W(WB), .SEED(12'd1)) u1 (
    .clk(clk), .rst(rst_b), .en(en_b), .dir_down(dn_b), .addr(addr_b), .last(last_b));

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [WB-1:0] seq [NB];
  bit            seen [NB];

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int zero_at;
    int last_cnt;
    // reset state
    @(negedge clk); @(negedge clk);
    rst = 1'b0; rst_b = 1'b0;
    check("R1 reset addr", int'(addr), 1);
    check("R7 last up at seed", int'(last), 0);
    dn = 1'b1; #1;
    check("R8 last down at seed", int'(last), 0);
    dn = 1'b0;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      en = VEC[i][6]; dn = VEC[i][5];
      @(negedge clk);
      check($sformatf("R2/R5/R6/R9 vec%0d addr", i), int'(addr), int'(VEC[i][4:1]));
      check($sformatf("R7/R8 vec%0d last", i), int'(last), int'(VEC[i][0]));
    end

    // reset priority over enable
    en = 1'b1; dn = 1'b0; @(negedge clk);
    check("R1 step before reset", int'(addr), 3);
    rst = 1'b1; @(negedge clk);
    rst = 1'b0;
    check("R1 reset beats enable", int'(addr), 1);
    en = 1'b0; @(negedge clk);
    check("R6 hold after reset", int'(addr), 1);

    // full up pass at W=12
    for (int k = 0; k < int'(NB); k++) seen[k] = 1'b0;
    seq[0] = addr_b; seen[addr_b] = 1'b1;
    zero_at = -1; last_cnt = 0;
    en_b = 1'b1; dn_b = 1'b0;
    for (int k = 1; k <= int'(NB); k++) begin
      if (last_b) begin
        last_cnt++;
        check("R7 up flag position", k, int'(NB));
      end
      @(negedge clk);
      if (k < int'(NB)) begin
        if (seen[addr_b]) check("R3 repeat", int'(addr_b), -1);
        seen[addr_b] = 1'b1;
        seq[k] = addr_b;
        if (addr_b == '0) zero_at = k;
      end else begin
        check("R3 back to seed", int'(addr_b), 1);
      end
    end
    check("R7 one up flag per pass", last_cnt, 1);
    check("R3 zero visited", int'(zero_at >= 1), 1);
    if (zero_at >= 1 && zero_at < int'(NB) - 1) begin
      check("R4 zero entry", int'(seq[zero_at-1]), 1 << (WB-1));
      check("R4 zero exit", int'(seq[zero_at+1]), 1);
    end

    // full down pass, mirror of the recorded up order
    dn_b = 1'b1; last_cnt = 0;
    for (int j = 1; j <= int'(NB); j++) begin
      if (last_b) begin
        last_cnt++;
        check("R8 down flag position", j, int'(NB));
      end
      @(negedge clk);
      check("R5 mirror order", int'(addr_b), int'(seq[(int'(NB) - j) % int'(NB)]));
    end
    check("R8 one down flag per pass", last_cnt, 1);
    en_b = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule